// File: doc/BRIEF.md
# Banked Register File with Program Status

This block holds the architectural register state of a 32-bit processor core. It has sixteen visible general registers. Index 15 is not one storage word: it is two stack pointers, a system one and a user one. The stack-select flag in the program status word decides which of the two an access to index 15 reaches. Beside the general file the block keeps the program status word, a table base, a return pointer, a 64-bit multiply/divide accumulator and the program counter. All of these can be read and written through their own ports.

Two combinational read ports and one write port serve the general registers. A 3-bit dedicated-register code selects one of the special registers for reading and writing. The status word has a full-word write and two field writes: one for the condition field and one for the interrupt-mask field. A warm reset gives fixed values to some fields only and leaves the rest as they were. A small sequencer then publishes the reset-vector fetch address for exactly one cycle.

The sequencer has three states. HOLD is entered at power-on and whenever warm reset is high. VEC lasts one cycle and presents the vector address. RUN is normal operation. The transitions are named as follows:
- HOLD→VEC: warm reset is low.
- VEC→RUN: always taken, unless warm reset is high, which gives VEC→HOLD.
- RUN→HOLD: warm reset is high.

Top module: `bankreg_file`

## Requirements
- R1: The status word keeps only the bits set in 0x001F073F. After a full-word write, every other bit reads as zero.
- R2: The condition field is status bits 5:0; bit 5 is the stack-select flag S. The interrupt-mask field is status bits 20:16. A condition-field write changes only bits 5:0, and an interrupt-mask write changes only bits 20:16. When either field write comes in the same cycle as a full-word write, the field write wins for its own bits.
- R3: Index 15 reaches the system stack pointer when S=0 and the user stack pointer when S=1, for reads and for writes. A write in the same cycle as a change of S uses the S value from before the clock edge.
- R4: Indices 0 to 14 are plain registers, and a write takes effect at the next rising edge. Both read ports are combinational and independent. In the cycle of a write to the register being read, a read returns the old value.
- R5: The dedicated codes are 0 table base, 1 return pointer, 2 system stack pointer, 3 user stack pointer, 4 accumulator bits 63:32 and 5 accumulator bits 31:0. Codes 6 and 7 read as zero, and writes to them change nothing. If a dedicated write and a general write reach the same stack pointer in one cycle, the dedicated write wins.
- R6: A warm-reset cycle sets the status word to (old & 0x0000060F) | 0x000F0000. It also sets the table base to 0x000FFC00 and the system stack pointer to 0. All other registers keep their values.
- R7: Power-on reset (rst_n low) puts the sequencer in HOLD. It sets the status word to 0x000F0000, the table base to 0x000FFC00 and every other register to 0.
- R8: The first cycle after HOLD with warm reset low is VEC. In VEC, vec_valid is 1 for exactly that one cycle and vec_addr equals table base + 0x3FC. In HOLD and RUN, vec_valid is 0.
- R9: All write ports are ignored in HOLD, in VEC and in any cycle where warm reset is high.
- R10: The program counter always stores bit 0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| ded_code | input | 3 | Dedicated register select code |
| ded_wr | input | 1 | Dedicated register write enable |
| ded_wdata | input | 32 | Dedicated register write data |
| ded_rdata | output | 32 | Dedicated register read data |
| psw_wr | input | 1 | Full status word write enable |
| psw_wdata | input | 32 | Full status word write data |
| psw_rdata | output | 32 | Status word value |
| cc_wr | input | 1 | Condition field write enable |
| cc_wdata | input | 6 | Condition field write data |
| im_wr | input | 1 | Interrupt-mask field write enable |
| im_wdata | input | 5 | Interrupt-mask field write data |
| pc_wr | input | 1 | Program counter write enable |
| pc_wdata | input | 32 | Program counter write data |
| pc_rdata | output | 32 | Program counter value |
| vec_valid | output | 1 | Reset-vector address valid (VEC state) |
| vec_addr | output | 32 | Reset-vector fetch address |

## Verification
The bench targets the following corner cases:
- Index 15 written in the same cycle as S flips. A design that used the new S would put the value into the other stack pointer.
- A dedicated write and a general write colliding on one stack pointer. A design with the wrong priority would keep the general write's data.
- Field writes combined with a full-word status write. A design with the wrong priority would lose the field data.
- A register read in the cycle it is written. A design that forwards the write would return the new value one cycle early.
- The warm-reset sequence, which must keep the status bits the formula preserves and leave the other registers alone. A design that cleared the whole status word or the user stack pointer, accepted writes during HOLD or VEC, or held vec_valid longer than one cycle would be caught by these checks.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int XW = 32;

    localparam logic [XW-1:0] PSW_KEEP = 32'h001F_073F;
    localparam logic [XW-1:0] PSW_HOLD = 32'h0000_060F;
    localparam logic [XW-1:0] PSW_SET  = 32'h000F_0000;

    localparam int CC_LO = 0;
    localparam int CC_W  = 6;
    localparam int IM_LO = 16;
    localparam int IM_W  = 5;
    localparam int S_BIT = 5;

    typedef enum logic [2:0] {
        DR_TABLE = 3'd0,
        DR_RET   = 3'd1,
        DR_SSP   = 3'd2,
        DR_USP   = 3'd3,
        DR_MULHI = 3'd4,
        DR_MULLO = 3'd5
    } dreg_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_VEC  = 2'd1,
        ST_RUN  = 2'd2
    } seq_e;
endpackage

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
    import rbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst,
    output logic wr_ok,
    output logic vec_pulse
);
    seq_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD: if (!warm_rst) st_d = ST_VEC;
            ST_VEC:  st_d = warm_rst ? ST_HOLD : ST_RUN;
            ST_RUN:  if (warm_rst) st_d = ST_HOLD;
            default: st_d = ST_HOLD;
        endcase
    end

    always_comb begin
        wr_ok     = (st_q == ST_RUN) && !warm_rst;
        vec_pulse = (st_q == ST_VEC);
    end

    // R8: leaving HOLD always passes through one VEC cycle
    a_r8_vec_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !warm_rst) |=> vec_pulse);

    // R8: the vector pulse never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pulse |=> !vec_pulse);
endmodule

// File: rtl/rbk_status.sv
module rbk_status
    import rbk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          wr_ok,
    input  logic          ps_wr,
    input  logic [XW-1:0] ps_wdata,
    input  logic          cc_wr,
    input  logic [CC_W-1:0] cc_wdata,
    input  logic          im_wr,
    input  logic [IM_W-1:0] im_wdata,
    output logic [XW-1:0] ps_q
);
    logic [XW-1:0] ps_d;

    always_comb begin
        ps_d = ps_q;
        if (warm_rst) begin
            ps_d = (ps_q & PSW_HOLD) | PSW_SET;
        end else if (wr_ok) begin
            if (ps_wr) ps_d = ps_wdata & PSW_KEEP;
            if (cc_wr) ps_d[CC_LO +: CC_W] = cc_wdata;
            if (im_wr) ps_d[IM_LO +: IM_W] = im_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= PSW_SET;
        else        ps_q <= ps_d;
    end

    // R1: a lone full-word write keeps only the implemented bits
    a_r1_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && ps_wr && !cc_wr && !im_wr && !warm_rst)
        |=> ps_q == ($past(ps_wdata) & PSW_KEEP));

    // R2: a lone condition-field write leaves all higher bits untouched
    a_r2_cc_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cc_wr && !ps_wr && !im_wr && !warm_rst)
        |=> (ps_q[XW-1:CC_W] == $past(ps_q[XW-1:CC_W])) && (ps_q[CC_W-1:0] == $past(cc_wdata)));

    // R6: warm reset loads mask 15, clears S, keeps bits 10:9 and 3:0
    a_r6_psw_reset: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (ps_q[20:16] == 5'd15) && !ps_q[S_BIT]
                     && (ps_q[10:9] == $past(ps_q[10:9])) && (ps_q[3:0] == $past(ps_q[3:0])));
endmodule

// File: rtl/rbk_gpr.sv
module rbk_gpr
    import rbk_pkg::*;
#(
    parameter int NUM_VIS = 16,
    parameter int NUM_RD  = 2,
    localparam int IDX_W  = $clog2(NUM_VIS),
    localparam int LAST   = NUM_VIS - 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst,
    input  logic wr_ok,
    input  logic s_sel,
    input  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx,
    output logic [NUM_RD-1:0][XW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XW-1:0]    wr_data,
    input  logic             ssp_wr,
    input  logic             usp_wr,
    input  logic [XW-1:0]    sp_wdata,
    output logic [XW-1:0]    ssp_q,
    output logic [XW-1:0]    usp_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

    logic [XW-1:0] gpr_q [0:LAST-1];
    logic gp_we, sp_gen_we;

    always_comb begin
        gp_we     = wr_ok && wr_en && (wr_idx != LAST_IDX);
        sp_gen_we = wr_ok && wr_en && (wr_idx == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAST; i++) gpr_q[i] <= '0;
        end else if (gp_we) begin
            gpr_q[wr_idx] <= wr_data;
        end
    end

    // system stack pointer: dedicated write outranks general write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ssp_q <= '0;
        else if (warm_rst)                ssp_q <= '0;
        else if (wr_ok && ssp_wr)         ssp_q <= sp_wdata;
        else if (sp_gen_we && !s_sel)     ssp_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       usp_q <= '0;
        else if (wr_ok && usp_wr)         usp_q <= sp_wdata;
        else if (sp_gen_we && s_sel)      usp_q <= wr_data;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] == LAST_IDX) ? (s_sel ? usp_q : ssp_q)
                                                    : gpr_q[rd_idx[p]];
    end

    // R3: index 15 with S=0 lands in the system pointer only
    a_r3_sys_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_en && wr_idx == LAST_IDX && !s_sel && !ssp_wr && !usp_wr && !warm_rst)
        |=> (ssp_q == $past(wr_data)) && (usp_q == $past(usp_q)));

    // R3: index 15 with S=1 lands in the user pointer only
    a_r3_usr_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_en && wr_idx == LAST_IDX && s_sel && !ssp_wr && !usp_wr && !warm_rst)
        |=> (usp_q == $past(wr_data)) && (ssp_q == $past(ssp_q)));

    // R5: dedicated write wins a collision on the system pointer
    a_r5_ded_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && ssp_wr && wr_en && wr_idx == LAST_IDX && !s_sel && !warm_rst)
        |=> ssp_q == $past(sp_wdata));

    // R6: warm reset clears the system pointer, keeps the user pointer
    a_r6_sp_reset: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (ssp_q == '0) && (usp_q == $past(usp_q)));
endmodule

// File: rtl/rbk_special.sv
module rbk_special
    import rbk_pkg::*;
#(
    parameter logic [XW-1:0] TBR_INIT = 32'h000F_FC00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          wr_ok,
    input  logic [2:0]    dcode,
    input  logic          d_wr,
    input  logic [XW-1:0] d_wdata,
    output logic [XW-1:0] d_rdata,
    input  logic [XW-1:0] ssp_q,
    input  logic [XW-1:0] usp_q,
    output logic          ssp_wr,
    output logic          usp_wr,
    input  logic          pc_wr,
    input  logic [XW-1:0] pc_wdata,
    output logic [XW-1:0] pc_q,
    output logic [XW-1:0] tbr_q
);
    localparam logic [XW-1:0] PC_ALIGN = ~XW'(1);

    logic [XW-1:0]   rp_q;
    logic [2*XW-1:0] md_q;
    logic tb_we, rp_we, mh_we, ml_we;

    always_comb begin
        tb_we = 1'b0; rp_we = 1'b0; mh_we = 1'b0; ml_we = 1'b0;
        ssp_wr = 1'b0; usp_wr = 1'b0;
        d_rdata = '0;
        unique case (dcode)
            DR_TABLE: begin d_rdata = tbr_q;           tb_we  = d_wr; end
            DR_RET:   begin d_rdata = rp_q;            rp_we  = d_wr; end
            DR_SSP:   begin d_rdata = ssp_q;           ssp_wr = d_wr; end
            DR_USP:   begin d_rdata = usp_q;           usp_wr = d_wr; end
            DR_MULHI: begin d_rdata = md_q[2*XW-1:XW]; mh_we  = d_wr; end
            DR_MULLO: begin d_rdata = md_q[XW-1:0];    ml_we  = d_wr; end
            default:  d_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tbr_q <= TBR_INIT;
        else if (warm_rst)       tbr_q <= TBR_INIT;
        else if (wr_ok && tb_we) tbr_q <= d_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
            md_q <= '0;
            pc_q <= '0;
        end else if (wr_ok) begin
            if (rp_we) rp_q <= d_wdata;
            if (mh_we) md_q[2*XW-1:XW] <= d_wdata;
            if (ml_we) md_q[XW-1:0] <= d_wdata;
            if (pc_wr) pc_q <= pc_wdata & PC_ALIGN;
        end
    end

    // R10: the stored counter is always even and keeps the upper bits
    a_r10_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && pc_wr && !warm_rst)
        |=> !pc_q[0] && (pc_q[XW-1:1] == $past(pc_wdata[XW-1:1])));

    // R5: reserved codes never disturb the special registers
    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (dcode[2:1] == 2'b11 && d_wr && !warm_rst)
        |=> $stable(tbr_q) && $stable(rp_q) && $stable(md_q));

    // R6: warm reset reloads the table base
    a_r6_tbr_reset: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> tbr_q == TBR_INIT);
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import rbk_pkg::*;
#(
    parameter int            NUM_VIS  = 16,
    parameter logic [XW-1:0] TBR_INIT = 32'h000F_FC00,
    parameter logic [XW-1:0] VEC_OFS  = 32'h0000_03FC,
    localparam int IDX_W = $clog2(NUM_VIS),
    localparam int NUM_RD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [XW-1:0]    rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [XW-1:0]    rd_b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XW-1:0]    wr_data,
    input  logic [2:0]       ded_code,
    input  logic             ded_wr,
    input  logic [XW-1:0]    ded_wdata,
    output logic [XW-1:0]    ded_rdata,
    input  logic             psw_wr,
    input  logic [XW-1:0]    psw_wdata,
    output logic [XW-1:0]    psw_rdata,
    input  logic             cc_wr,
    input  logic [CC_W-1:0]  cc_wdata,
    input  logic             im_wr,
    input  logic [IM_W-1:0]  im_wdata,
    input  logic             pc_wr,
    input  logic [XW-1:0]    pc_wdata,
    output logic [XW-1:0]    pc_rdata,
    output logic             vec_valid,
    output logic [XW-1:0]    vec_addr
);
    logic wr_ok, vec_pulse;
    logic ssp_wr, usp_wr;
    logic [XW-1:0] ssp_q, usp_q, tbr_q, ps_q;
    logic [NUM_RD-1:0][IDX_W-1:0] rd_idx;
    logic [NUM_RD-1:0][XW-1:0]    rd_data;

    assign rd_idx    = {rd_b_idx, rd_a_idx};
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign psw_rdata = ps_q;
    assign vec_valid = vec_pulse;
    assign vec_addr  = vec_pulse ? (tbr_q + VEC_OFS) : '0;

    rbk_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .wr_ok(wr_ok), .vec_pulse(vec_pulse)
    );

    rbk_status u_status (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_ok(wr_ok),
        .ps_wr(psw_wr), .ps_wdata(psw_wdata),
        .cc_wr(cc_wr), .cc_wdata(cc_wdata),
        .im_wr(im_wr), .im_wdata(im_wdata),
        .ps_q(ps_q)
    );

    rbk_gpr #(.NUM_VIS(NUM_VIS), .NUM_RD(NUM_RD)) u_gpr (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_ok(wr_ok),
        .s_sel(ps_q[S_BIT]),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ssp_wr(ssp_wr), .usp_wr(usp_wr), .sp_wdata(ded_wdata),
        .ssp_q(ssp_q), .usp_q(usp_q)
    );

    rbk_special #(.TBR_INIT(TBR_INIT)) u_special (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_ok(wr_ok),
        .dcode(ded_code), .d_wr(ded_wr), .d_wdata(ded_wdata), .d_rdata(ded_rdata),
        .ssp_q(ssp_q), .usp_q(usp_q), .ssp_wr(ssp_wr), .usp_wr(usp_wr),
        .pc_wr(pc_wr), .pc_wdata(pc_wdata), .pc_q(pc_rdata),
        .tbr_q(tbr_q)
    );

    // R9: no write may land while the sequencer is outside RUN
    a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok) |=> (pc_rdata == $past(pc_rdata)));
endmodule

// File: tb/sim_bankreg_file.sv
module sim_bankreg_file;
    logic        clk = 1'b0;
    logic        rst_n, warm_rst;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, ded_wr, psw_wr, cc_wr, im_wr, pc_wr;
    logic [2:0]  ded_code;
    logic [31:0] ded_wdata, ded_rdata, psw_wdata, psw_rdata, pc_wdata, pc_rdata;
    logic [5:0]  cc_wdata;
    logic [4:0]  im_wdata;
    logic        vec_valid;
    logic [31:0] vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bankreg_file u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ded_code(ded_code), .ded_wr(ded_wr), .ded_wdata(ded_wdata), .ded_rdata(ded_rdata),
        .psw_wr(psw_wr), .psw_wdata(psw_wdata), .psw_rdata(psw_rdata),
        .cc_wr(cc_wr), .cc_wdata(cc_wdata), .im_wr(im_wr), .im_wdata(im_wdata),
        .pc_wr(pc_wr), .pc_wdata(pc_wdata), .pc_rdata(pc_rdata),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    // entry: {S, index, data}
    localparam logic [36:0] TAB [0:7] = '{
        {1'b0, 4'd0,  32'hA5A5_0001},
        {1'b0, 4'd7,  32'h0707_0707},
        {1'b0, 4'd14, 32'hE000_000E},
        {1'b0, 4'd15, 32'h1111_0000},
        {1'b1, 4'd15, 32'h2222_0000},
        {1'b1, 4'd3,  32'h1000_0003},
        {1'b1, 4'd9,  32'h9999_0009},
        {1'b0, 4'd15, 32'h3333_0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 0; ded_wr = 0; psw_wr = 0; cc_wr = 0; im_wr = 0; pc_wr = 0;
    endtask

    task automatic gw(input logic [3:0] i, input logic [31:0] d);
        wr_en = 1; wr_idx = i; wr_data = d; step(); wr_en = 0;
    endtask

    task automatic dw(input logic [2:0] c, input logic [31:0] d);
        ded_wr = 1; ded_code = c; ded_wdata = d; step(); ded_wr = 0;
    endtask

    task automatic dr(input logic [2:0] c, output logic [31:0] v);
        ded_code = c; #1; v = ded_rdata;
    endtask

    task automatic rd(input logic [3:0] i, output logic [31:0] v);
        rd_a_idx = i; #1; v = rd_a_data;
    endtask

    task automatic pw(input logic [31:0] d);
        psw_wr = 1; psw_wdata = d; step(); psw_wr = 0;
    endtask

    task automatic set_s(input logic s);
        cc_wr = 1; cc_wdata = {s, 5'b0}; step(); cc_wr = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 0; warm_rst = 0; quiet();
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        ded_code = 0; ded_wdata = 0; psw_wdata = 0; cc_wdata = 0; im_wdata = 0; pc_wdata = 0;
        repeat (3) step();

        // R7: power-on values
        chk("R7 psw at power-on", psw_rdata, 32'h000F_0000);
        dr(3'd0, v); chk("R7 table base at power-on", v, 32'h000F_FC00);
        dr(3'd3, v); chk("R7 user sp at power-on", v, 0);
        chk("R8 no vector in HOLD", vec_valid, 0);

        rst_n = 1;
        step();
        chk("R8 vec_valid after release", vec_valid, 1);
        chk("R8 vector address", vec_addr, 32'h000F_FFFC);
        wr_en = 1; wr_idx = 4'd1; wr_data = 32'hDEAD_BEEF;   // during VEC
        step(); wr_en = 0;
        chk("R8 vec_valid one cycle", vec_valid, 0);
        rd(4'd1, v); chk("R9 write in VEC ignored", v, 0);

        // table walk: R4 plain registers, R3 banked index 15
        for (int k = 0; k < 8; k++) begin
            logic [36:0] e;
            e = TAB[k];
            set_s(e[36]);
            gw(e[35:32], e[31:0]);
            rd_a_idx = e[35:32]; rd_b_idx = e[35:32]; #1;
            chk("R4 table port A", rd_a_data, e[31:0]);
            chk("R4 table port B", rd_b_data, e[31:0]);
            if (e[35:32] == 4'd15) begin
                dr(e[36] ? 3'd3 : 3'd2, v);
                chk("R3 table bank target", v, e[31:0]);
            end
        end
        rd(4'd15, v); chk("R3 R15 with S=0 reads system sp", v, 32'h3333_0000);
        dr(3'd3, v); chk("R3 user sp untouched", v, 32'h2222_0000);
        set_s(1'b1);
        rd(4'd15, v); chk("R3 R15 with S=1 reads user sp", v, 32'h2222_0000);
        rd_b_idx = 4'd0; #1; chk("R4 R0 kept", rd_b_data, 32'hA5A5_0001);

        // R4: read returns old value in the write cycle
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'h2000_0003;
        rd_a_idx = 4'd3; rd_b_idx = 4'd9; #1;
        chk("R4 old value during write", rd_a_data, 32'h1000_0003);
        chk("R4 other port independent", rd_b_data, 32'h9999_0009);
        step(); wr_en = 0; #1;
        chk("R4 new value after edge", rd_a_data, 32'h2000_0003);

        // R3: S flip and R15 write in one cycle use the old S
        pw(32'h0);
        cc_wr = 1; cc_wdata = 6'h20;
        wr_en = 1; wr_idx = 4'd15; wr_data = 32'h5555_AAAA;
        step(); quiet();
        dr(3'd2, v); chk("R3 old S selects system sp", v, 32'h5555_AAAA);
        dr(3'd3, v); chk("R3 user sp unchanged", v, 32'h2222_0000);
        rd(4'd15, v); chk("R3 R15 now reads user sp", v, 32'h2222_0000);

        // R1: implemented bits only
        pw(32'hFFFF_FFFF); chk("R1 all-ones write", psw_rdata, 32'h001F_073F);
        pw(32'hFFE0_F8C0); chk("R1 unimplemented bits zero", psw_rdata, 32'h0);

        // R2: field writes
        pw(32'h001F_073F);
        cc_wr = 1; cc_wdata = 6'h00; step(); cc_wr = 0;
        chk("R2 condition field alone", psw_rdata, 32'h001F_0700);
        im_wr = 1; im_wdata = 5'h03; step(); im_wr = 0;
        chk("R2 mask field alone", psw_rdata, 32'h0003_0700);
        psw_wr = 1; psw_wdata = 32'h0; cc_wr = 1; cc_wdata = 6'h2A; step(); quiet();
        chk("R2 field beats word write", psw_rdata, 32'h0000_002A);

        // R5: dedicated map
        pw(32'h0);
        dw(3'd0, 32'h1234_5000);
        dw(3'd1, 32'hCAFE_0001);
        dw(3'd4, 32'h0BAD_F00D);
        dw(3'd5, 32'h600D_CAFE);
        dr(3'd0, v); chk("R5 code 0 table base", v, 32'h1234_5000);
        dr(3'd1, v); chk("R5 code 1 return pointer", v, 32'hCAFE_0001);
        dr(3'd4, v); chk("R5 code 4 accumulator high", v, 32'h0BAD_F00D);
        dr(3'd5, v); chk("R5 code 5 accumulator low", v, 32'h600D_CAFE);
        dw(3'd6, 32'hFFFF_FFFF);
        dw(3'd7, 32'hFFFF_FFFF);
        dr(3'd6, v); chk("R5 code 6 reads zero", v, 0);
        dr(3'd7, v); chk("R5 code 7 reads zero", v, 0);
        dr(3'd1, v); chk("R5 reserved write no effect", v, 32'hCAFE_0001);
        dr(3'd4, v); chk("R5 reserved write no effect hi", v, 32'h0BAD_F00D);
        wr_en = 1; wr_idx = 4'd15; wr_data = 32'hAAAA_0001;
        ded_wr = 1; ded_code = 3'd2; ded_wdata = 32'hBBBB_0002;
        step(); quiet();
        dr(3'd2, v); chk("R5 dedicated write wins", v, 32'hBBBB_0002);

        // R10: counter alignment
        pc_wr = 1; pc_wdata = 32'h0000_1235; step(); pc_wr = 0;
        chk("R10 pc bit 0 cleared", pc_rdata, 32'h0000_1234);

        // R6 / R9: warm reset
        gw(4'd5, 32'h0000_0005);
        pw(32'h001F_073F);
        warm_rst = 1;
        wr_en = 1; wr_idx = 4'd5; wr_data = 32'h0000_0099;
        ded_wr = 1; ded_code = 3'd1; ded_wdata = 32'h7777_7777;
        psw_wr = 1; psw_wdata = 32'hFFFF_FFFF;
        pc_wr = 1; pc_wdata = 32'h0000_4000;
        step(); step();
        chk("R8 no vector while warm reset held", vec_valid, 0);
        warm_rst = 0;
        step();
        chk("R8 vector after warm reset", vec_valid, 1);
        chk("R8 vector address after warm reset", vec_addr, 32'h000F_FFFC);
        step(); quiet();
        chk("R8 vector dropped", vec_valid, 0);
        chk("R6 psw after warm reset", psw_rdata, 32'h000F_060F);
        dr(3'd0, v); chk("R6 table base reloaded", v, 32'h000F_FC00);
        dr(3'd2, v); chk("R6 system sp cleared", v, 0);
        dr(3'd3, v); chk("R6 user sp kept", v, 32'h2222_0000);
        dr(3'd1, v); chk("R9 return pointer write blocked", v, 32'hCAFE_0001);
        dr(3'd5, v); chk("R6 accumulator kept", v, 32'h600D_CAFE);
        rd(4'd5, v); chk("R9 R5 write blocked", v, 32'h0000_0005);
        chk("R9 pc write blocked", pc_rdata, 32'h0000_1234);

        summary();
        $finish;
    end
endmodule